// File: doc/BRIEF.md
# Interrupt Coalescing Packet Counter

This block lowers the interrupt rate of a packet DMA channel. It keeps a live count of packets the DMA engine has finished (sent or received) that software has not yet serviced. A threshold interrupt is raised while that count is at or above a programmable threshold. A timeout interrupt is raised when packets have waited unserviced for a programmable number of millisecond ticks. The timeout catches light traffic that never reaches the threshold.

Software programs the threshold and the wait bound through a simple write port. It services packets by writing the value 1 to the counter selector, which removes exactly one packet from the count. A hardware increment and a software decrement in the same cycle are merged so that no event is lost. The tick source, the bus decode and the interrupt controller sit outside this block. The controller's pending state is fed back on `irq_pending`.

Top module: `pkt_coalesce_top`

## Requirements
- R1: After a synchronous reset, `pkt_count` is 0, both interrupts are low, and the threshold and the wait bound are both 0.
- R2: Each cycle with `pkt_done` high raises `pkt_count` by one, visible after the next rising edge.
- R3: A write with `wr_sel`=2 and `wr_data`=1 lowers the count by one. A write with `wr_sel`=2 and any other data value leaves the count unchanged.
- R4: A packet completion and a valid decrement in the same cycle leave the count unchanged.
- R5: A decrement at count 0 is ignored. A completion at the maximum count (2^CNT_W-1) leaves the count at the maximum.
- R6: With a nonzero threshold, `thr_irq` is high one cycle after any cycle in which the count is greater than or equal to the threshold, and low one cycle after any cycle in which it is below. The count keeps changing while the interrupt is high.
- R7: A threshold of 0 keeps `thr_irq` low.
- R8: While `irq_pending` is low, the count is nonzero and the wait bound B is nonzero, each `ms_tick` advances a wait timer. The B-th such tick gives a one-cycle `timeout_irq` pulse after that edge, and the timer restarts from zero.
- R9: The wait timer is cleared whenever `irq_pending` is high or the count is 0, and a wait bound of 0 keeps `timeout_irq` low.
- R10: `wr_sel`=0 loads the threshold from `wr_data[7:0]`, and `wr_sel`=1 loads the wait bound from `wr_data[9:0]`. Upper data bits are ignored, and `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_done | input | 1 | One-cycle pulse per packet finished by the DMA engine |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 threshold, 1 wait bound, 2 counter decrement, 3 none |
| wr_data | input | DATA_W (16) | Write data |
| irq_pending | input | 1 | Interrupt for this channel is pending at the controller |
| ms_tick | input | 1 | One-cycle millisecond tick |
| pkt_count | output | CNT_W (8) | Live unserviced packet count |
| thr_irq | output | 1 | Threshold interrupt (level) |
| timeout_irq | output | 1 | Wait-bound timeout interrupt (one-cycle pulse) |

## Verification
The embedded properties assume that every input is a known value on each rising edge once reset is released. They also assume that reset is high from the first edge, so that the counter, threshold and timer registers start from defined values. The bench changes inputs only on falling edges and holds reset through the first cycles. Its stimulus uses single-cycle packet and tick pulses and one write per cycle, so merges, saturation and timer restarts come only from those legal input combinations.

// File: rtl/pkt_coal_pkg.sv
package pkt_coal_pkg;
  typedef enum logic [1:0] {
    SEL_THRESH = 2'd0,
    SEL_BOUND  = 2'd1,
    SEL_DEC    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pkt_cfg_regs.sv
module pkt_cfg_regs
  import pkt_coal_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int THR_W   = 8,
  parameter int BOUND_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [THR_W-1:0]   thresh,
  output logic [BOUND_W-1:0] bound,
  output logic               dec_req
);
  localparam logic [DATA_W-1:0] DEC_CODE = DATA_W'(1);

  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      thresh <= '0;
      bound  <= '0;
    end else if (wr_en) begin
      if (sel == SEL_THRESH) thresh <= wr_data[THR_W-1:0];
      if (sel == SEL_BOUND)  bound  <= wr_data[BOUND_W-1:0];
    end
  end

  // only the value 1 is a legal counter write; anything else is dropped
  assign dec_req = wr_en && (sel == SEL_DEC) && (wr_data == DEC_CODE);

  // R10: a write to another selector leaves the threshold untouched
  assert_thr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == SEL_THRESH) |=> $stable(thresh));
endmodule

// File: rtl/pkt_count_unit.sv
module pkt_count_unit #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
        2'b01:   if (cnt != '0)      cnt <= cnt - CNT_W'(1);
        default: ;  // idle, or both at once: the two cancel
      endcase
    end
  end

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && cnt != CNT_MAX) |=> cnt == $past(cnt) + CNT_W'(1));
  assert_dec_step_R3: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));
  assert_merge_R4: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> $stable(cnt));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !inc) |=> cnt == '0);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !dec) |=> cnt == CNT_MAX);
endmodule

// File: rtl/pkt_thresh_cmp.sv
module pkt_thresh_cmp #(
  parameter int CNT_W = 8,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [THR_W-1:0] thresh,
  output logic             irq
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] cnt_x, thr_x;
  logic             hit;

  assign cnt_x = CMP_W'(cnt);
  assign thr_x = CMP_W'(thresh);
  assign hit   = (thresh != '0) && (cnt_x >= thr_x);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= hit;
  end

  assert_thr_off_R7: assert property (@(posedge clk) disable iff (rst)
    (thresh == '0) |=> !irq);
  assert_below_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_x < thr_x) |=> !irq);
endmodule

// File: rtl/pkt_wait_timer.sv
module pkt_wait_timer #(
  parameter int CNT_W   = 8,
  parameter int BOUND_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pending,
  input  logic               tick,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [BOUND_W-1:0] bound,
  output logic               timeout
);
  logic [BOUND_W-1:0] elapsed;
  logic               run, fire;

  assign run  = !pending && (cnt != '0) && (bound != '0);
  // >= rather than == so a bound lowered below the elapsed time still fires
  assign fire = run && tick && (elapsed >= bound - BOUND_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= fire;
      if (!run || fire)  elapsed <= '0;
      else if (tick)     elapsed <= elapsed + BOUND_W'(1);
    end
  end

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (pending || cnt == '0) |=> elapsed == '0);
  assert_bound_off_R9: assert property (@(posedge clk) disable iff (rst)
    (bound == '0) |=> !timeout);
  assert_tick_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (!tick || pending) |=> !timeout);
endmodule

// File: rtl/pkt_coalesce_top.sv
module pkt_coalesce_top #(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  parameter int THR_W   = 8,
  parameter int BOUND_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_done,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_pending,
  input  logic              ms_tick,
  output logic [CNT_W-1:0]  pkt_count,
  output logic              thr_irq,
  output logic              timeout_irq
);
  logic [THR_W-1:0]   thresh;
  logic [BOUND_W-1:0] bound;
  logic               dec_req;

  pkt_cfg_regs #(.DATA_W(DATA_W), .THR_W(THR_W), .BOUND_W(BOUND_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .thresh(thresh), .bound(bound), .dec_req(dec_req)
  );

  pkt_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(pkt_done), .dec(dec_req), .cnt(pkt_count)
  );

  pkt_thresh_cmp #(.CNT_W(CNT_W), .THR_W(THR_W)) u_thr (
    .clk(clk), .rst(rst), .cnt(pkt_count), .thresh(thresh), .irq(thr_irq)
  );

  pkt_wait_timer #(.CNT_W(CNT_W), .BOUND_W(BOUND_W)) u_tmr (
    .clk(clk), .rst(rst), .pending(irq_pending), .tick(ms_tick),
    .cnt(pkt_count), .bound(bound), .timeout(timeout_irq)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pkt_count == '0 && !thr_irq && !timeout_irq));
endmodule

// File: tb/tb_pkt_coalesce_top.sv
module tb_pkt_coalesce_top;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pkt_done = 0, wr_en = 0, irq_pending = 0, ms_tick = 0;
  logic [1:0] wr_sel = 2'd3;
  logic [DATA_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] pkt_count;
  logic thr_irq, timeout_irq;

  always #2.5 clk = ~clk;  // 200 MHz

  pkt_coalesce_top dut (
    .clk(clk), .rst(rst), .pkt_done(pkt_done), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .irq_pending(irq_pending), .ms_tick(ms_tick),
    .pkt_count(pkt_count), .thr_irq(thr_irq), .timeout_irq(timeout_irq)
  );

  typedef struct { int cnt; bit ti; bit to; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  // reference state, built from the requirements
  int m_cnt = 0, m_thr = 0, m_bnd = 0, m_tmr = 0;
  bit m_ti = 0, m_to = 0;

  task automatic step(bit pd, bit we, int sel, int wd, bit pend, bit tk, string tag);
    bit dec, run, fire, ti_n;
    exp_t e;
    @(negedge clk);
    pkt_done = pd; wr_en = we; wr_sel = sel[1:0]; wr_data = wd[DATA_W-1:0];
    irq_pending = pend; ms_tick = tk;
    @(posedge clk);
    dec  = we && sel == 2 && (wd & 16'hFFFF) == 1;
    run  = !pend && m_cnt != 0 && m_bnd != 0;
    fire = run && tk && (m_tmr + 1 >= m_bnd);
    ti_n = m_thr != 0 && m_cnt >= m_thr;
    m_to = fire;
    m_ti = ti_n;
    if (!run || fire) m_tmr = 0; else if (tk) m_tmr = m_tmr + 1;
    if (pd && !dec && m_cnt < CMAX) m_cnt = m_cnt + 1;
    else if (dec && !pd && m_cnt > 0) m_cnt = m_cnt - 1;
    if (we && sel == 0) m_thr = wd & 8'hFF;
    if (we && sel == 1) m_bnd = wd & 10'h3FF;
    e.cnt = m_cnt; e.ti = m_ti; e.to = m_to; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n, bit pend, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 3, 0, pend, 0, tag);
  endtask

  // monitor: compare one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      total++;
      if (int'(pkt_count) != e.cnt || thr_irq != e.ti || timeout_irq != e.to) begin
        bad++;
        $display("FAIL %s: cnt=%0d/%0d thr_irq=%0b/%0b timeout_irq=%0b/%0b (actual/expected)",
                 e.tag, pkt_count, e.cnt, thr_irq, e.ti, timeout_irq, e.to);
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    idle(3, 0, "R1");
    // R10: upper bits of the threshold write are ignored -> threshold 3
    step(0, 1, 0, 16'h1203, 0, 0, "R10");
    for (int i = 0; i < 4; i++) step(1, 0, 3, 0, 0, 0, "R2");
    idle(2, 0, "R6");
    // R3: legal and illegal decrement values
    step(0, 1, 2, 1, 0, 0, "R3");
    step(0, 1, 2, 2, 0, 0, "R3");
    step(0, 1, 2, 0, 0, 0, "R3");
    step(0, 1, 2, 16'h8001, 0, 0, "R3");
    idle(2, 0, "R6");
    // R4: merged increment and decrement
    step(1, 1, 2, 1, 0, 0, "R4");
    step(1, 1, 2, 1, 0, 0, "R4");
    // R6: drop below threshold, then climb back while irq is live
    step(0, 1, 2, 1, 0, 0, "R6");
    idle(2, 0, "R6");
    step(1, 0, 3, 0, 0, 0, "R6");
    step(1, 0, 3, 0, 0, 0, "R6");
    idle(2, 0, "R6");
    // R5: drain to zero and keep decrementing
    for (int i = 0; i < 8; i++) step(0, 1, 2, 1, 0, 0, "R5");
    step(1, 1, 2, 1, 0, 0, "R4");
    idle(2, 0, "R5");
    // R7: threshold 0 disables the threshold interrupt
    step(0, 1, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 5; i++) step(1, 0, 3, 0, 0, 0, "R7");
    idle(2, 0, "R7");
    // R10/R8: bound 0x0C05 -> 5; ticks every 3 cycles, expect a pulse
    step(0, 1, 1, 16'h0C05, 0, 0, "R10");
    step(0, 1, 3, 16'h00FF, 0, 0, "R10");
    for (int t = 0; t < 12; t++) begin
      step(0, 0, 3, 0, 0, 1, "R8");
      idle(2, 0, "R8");
    end
    // R9: pending holds the timer in reset
    for (int t = 0; t < 8; t++) begin
      step(0, 0, 3, 0, 1, 1, "R9");
      step(0, 0, 3, 0, 1, 0, "R9");
    end
    // R8: bound 1 fires on every tick
    step(0, 1, 1, 1, 0, 0, "R8");
    for (int t = 0; t < 3; t++) step(0, 0, 3, 0, 0, 1, "R8");
    // R9: bound 0 disables timeout
    step(0, 1, 1, 0, 0, 0, "R9");
    for (int t = 0; t < 6; t++) step(0, 0, 3, 0, 0, 1, "R9");
    // R9: count back to zero clears the timer
    step(0, 1, 1, 3, 0, 0, "R9");
    step(0, 0, 3, 0, 0, 1, "R9");
    step(0, 0, 3, 0, 0, 1, "R9");
    for (int i = 0; i < 6; i++) step(0, 1, 2, 1, 0, 0, "R9");
    step(1, 0, 3, 0, 0, 1, "R9");
    step(0, 0, 3, 0, 0, 1, "R9");
    step(0, 0, 3, 0, 0, 1, "R9");
    step(0, 0, 3, 0, 0, 1, "R9");
    // R5: saturate at the maximum
    step(0, 1, 1, 0, 0, 0, "R5");
    step(0, 1, 0, 200, 0, 0, "R6");
    for (int i = 0; i < CMAX + 6; i++) step(1, 0, 3, 0, 0, 0, "R5");
    step(1, 1, 2, 1, 0, 0, "R4");
    step(0, 1, 2, 1, 0, 0, "R5");
    idle(3, 0, "R5");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule